// File: doc/BRIEF.md
# I2C register slave

This block is a standard-mode I2C target that gives a bus master byte-wide access to a small register bank. SCL and SDA are oversampled by the system clock, cleaned by a synchronizer and a glitch filter, and turned into clock-edge, START and STOP events. The block answers one 7-bit address. The upper five bits are fixed and the lower two come from two pins that are compared live in every address phase, so four copies can share a bus. SDA is open-drain: the block only ever pulls it low through an output-enable.

A write transfer carries a pointer byte first and then data bytes. Each data byte is written at the pointer, and the pointer then steps by one. A transfer may carry the pointer alone and end with STOP or with a repeated START, so that a read can follow from that pointer. A read returns the byte at the pointer and then bytes from the following addresses, until the master answers with NACK. The register bank sits behind a plain address / write-data / write-strobe / read-data port. The current pointer is always presented on the address output.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 01011 followed by dev_sel_i[1] and then dev_sel_i[0]. It acknowledges by holding sda_oe_o high through the ninth SCL high period. Bit 0 of the byte is the direction: 0 means write, 1 means read.
- R2: dev_sel_i is not latched: a new level on it changes the matching address for the next transfer.
- R3: On an address mismatch the block does not acknowledge, gives no write strobe and leaves its pointer unchanged, and it ignores the bus until the next START.
- R4: In a write, the first byte after the address loads the pointer. Each later byte gives a one-cycle reg_we_o with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. The pointer then increments by one.
- R5: Every byte received in an addressed write, pointer byte included, is acknowledged.
- R6: A write that carries only the pointer byte, ended by STOP or by a repeated START, makes the next read start at that pointer.
- R7: A read shifts out the byte at the pointer MSB first, and the pointer increments after each byte. After a master ACK the next byte comes from the new pointer.
- R8: After the eighth bit of a read byte the block releases SDA. A master NACK on the ninth clock ends the transfer, and SDA stays released.
- R9: A START seen in any state, including partway through a data byte, returns the block to the address phase without a write strobe. A STOP returns it to idle with SDA released.
- R10: sda_oe_o changes only while the filtered SCL is low, so data the block drives is stable for the whole SCL high period.
- R11: After reset sda_oe_o and reg_we_o are low and the pointer (reg_addr_o) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| dev_sel_i | input | 2 | Live low bits of the device address |
| reg_addr_o | output | AW | Register pointer / bank address |
| reg_wdata_o | output | 8 | Write data to the bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Bank read data at reg_addr_o |

## Verification
The hardest situation to reach is a START that cuts into a data byte after the pointer is loaded. It has to leave the bank untouched and still let a read follow from that pointer. The bench drives the bus with bit-level tasks, so it can clock half a byte and then issue a repeated START. A read after that shows the pointer and the bank contents at the ports. The other hard cases are a pointer-only write joined to a read by a repeated START, and a read burst ended by NACK. The bench builds both from the same bit tasks and checks the pointer and data after each one.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_in_filt.sv
module i2c_in_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter int          AW         = 8,
  parameter logic [4:0]  DEV_PREFIX = 5'b01011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        dev_sel_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  input  logic [BYTE_W-1:0] rdata_i
);
  slv_state_e        st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rnw_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rnw_q    <= 1'b0;
      first_q  <= 1'b0;
      sda_oe_o <= 1'b0;
      ptr_o    <= '0;
      wdata_o  <= '0;
      we_o     <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (we_o) ptr_o <= ptr_o + AW'(1);  // step after the strobe cycle
      if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (sh_q[7:1] == {DEV_PREFIX, dev_sel_i}) begin
                sda_oe_o <= 1'b1;
                rnw_q    <= sh_q[0];
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rnw_q) begin
                sh_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                st_q     <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                first_q  <= 1'b1;
                st_q     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              sda_oe_o <= 1'b1;
              st_q     <= ST_WR_ACK;
              if (first_q) begin
                ptr_o   <= AW'(sh_q);
                first_q <= 1'b0;
              end else begin
                we_o    <= 1'b1;
                wdata_o <= sh_q;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                ptr_o    <= ptr_o + AW'(1);
                st_q     <= ST_RD_ACK;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i && sda_i) begin
              st_q <= ST_IDLE;  // master NACK
            end else if (scl_fall_i) begin
              cnt_q    <= '0;
              sh_q     <= rdata_i;
              sda_oe_o <= ~rdata_i[BYTE_W-1];
              st_q     <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         FILT_LEN   = 3,
  parameter logic [4:0] DEV_PREFIX = 5'b01011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        dev_sel_i,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic [1:0] raw, filt;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_in_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  i2c_cond_det u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_slv_fsm #(.AW(AW), .DEV_PREFIX(DEV_PREFIX)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_f),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .dev_sel_i (dev_sel_i),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (reg_addr_o),
    .wdata_o   (reg_wdata_o),
    .we_o      (reg_we_o),
    .rdata_i   (reg_rdata_i)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_f,
  input logic          sda_f,
  input logic          sda_oe_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_f));  // R10

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);  // R4

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + AW'(1)));  // R4

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> !sda_oe_o);  // R9
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f     (scl_f),
  .sda_f     (sda_f),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [1:0] dev_sel = 2'b10;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;
  logic [7:0] bank [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_q [$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .dev_sel_i(dev_sel), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  initial for (int i = 0; i < 256; i++) begin
    bank[i]    = 8'(i) ^ 8'h5A;
    exp_mem[i] = 8'(i) ^ 8'h5A;
  end
  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;
  assign reg_rdata = bank[reg_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) if (rst_ni && reg_we) begin
    if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write strobe", {reg_addr, reg_wdata}, 0);
    else begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cyc(input logic b, output logic smp, output logic early);
    sda_m = b;
    wt(10);
    scl_m = 1'b1;
    wt(2);
    early = sda_bus;
    wt(16);
    smp = sda_bus;
    wt(2);
    scl_m = 1'b0;
    wt(10);
  endtask

  task automatic i2c_start();
    if (!scl_m) begin
      sda_m = 1'b1; wt(10);
      scl_m = 1'b1; wt(20);
    end
    sda_m = 1'b0; wt(20);
    scl_m = 1'b0; wt(10);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(10);
    scl_m = 1'b1; wt(20);
    sda_m = 1'b1; wt(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s, e;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s, e);
    bit_cyc(1'b1, s, e);
    ack = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] d);
    logic s, e;
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1, s, e);
      chk(s == e, "R10 read bit stable over SCL high", s, e);
      d[i] = s;
    end
    bit_cyc(m_ack ? 1'b0 : 1'b1, s, e);
  endtask

  task automatic wr_data(input logic [7:0] p, input logic [7:0] d, input string req);
    bit ack;
    exp_q.push_back({p, d});
    exp_mem[p] = d;
    send_byte(d, ack);
    chk(ack, req, ack, 1);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    wt(5);
    rst_ni = 1'b1;
    wt(3);
    chk(sda_oe == 1'b0, "R11 sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R11 we after reset", reg_we, 0);
    chk(reg_addr == 8'h00, "R11 pointer after reset", reg_addr, 0);

    // write burst, dev_sel=10 -> address 0101110
    i2c_start();
    send_byte(8'h5C, ack); chk(ack, "R1 address ack", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R5 pointer byte ack", ack, 1);
    wr_data(8'h10, 8'hA5, "R5 data ack");
    wr_data(8'h11, 8'h3C, "R5 data ack");
    i2c_stop();
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    chk(reg_addr == 8'h12, "R4 pointer after burst", reg_addr, 8'h12);

    // mismatch: address 0101101 while dev_sel=10
    i2c_start();
    send_byte(8'h5A, ack); chk(!ack, "R3 no ack on mismatch", ack, 0);
    send_byte(8'h20, ack); chk(!ack, "R3 bus ignored", ack, 0);
    send_byte(8'h77, ack); chk(!ack, "R3 bus ignored", ack, 0);
    i2c_stop();
    chk(reg_addr == 8'h12, "R3 pointer untouched", reg_addr, 8'h12);

    // live pins: dev_sel=01 now matches 0101101
    dev_sel = 2'b01;
    i2c_start();
    send_byte(8'h5A, ack); chk(ack, "R2 new address ack", ack, 1);
    send_byte(8'h40, ack); chk(ack, "R5 pointer byte ack", ack, 1);
    wr_data(8'h40, 8'h99, "R5 data ack");
    i2c_stop();

    // pointer-only write, repeated START, read burst
    i2c_start();
    send_byte(8'h5A, ack);
    send_byte(8'h10, ack); chk(ack, "R6 pointer ack", ack, 1);
    i2c_start();
    send_byte(8'h5B, ack); chk(ack, "R1 read address ack", ack, 1);
    recv_byte(1'b1, d); chk(d == exp_mem[8'h10], "R6 first read at pointer", d, exp_mem[8'h10]);
    recv_byte(1'b1, d); chk(d == exp_mem[8'h11], "R7 second read byte", d, exp_mem[8'h11]);
    recv_byte(1'b0, d); chk(d == exp_mem[8'h12], "R7 third read byte", d, exp_mem[8'h12]);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    wt(10);
    chk(sda_oe == 1'b0, "R8 stays released", sda_oe, 0);
    i2c_stop();
    chk(reg_addr == 8'h13, "R7 pointer after read", reg_addr, 8'h13);

    // pointer-only write ended by STOP, then read
    i2c_start();
    send_byte(8'h5A, ack);
    send_byte(8'h40, ack);
    i2c_stop();
    i2c_start();
    send_byte(8'h5B, ack); chk(ack, "R6 read address ack", ack, 1);
    recv_byte(1'b0, d); chk(d == 8'h99, "R6 read after STOP", d, 8'h99);
    i2c_stop();

    // START partway through a data byte
    i2c_start();
    send_byte(8'h5A, ack);
    send_byte(8'h30, ack);
    begin
      logic s, e;
      bit_cyc(1'b1, s, e); bit_cyc(1'b0, s, e);
      bit_cyc(1'b1, s, e); bit_cyc(1'b1, s, e);
    end
    i2c_start();
    send_byte(8'h5B, ack); chk(ack, "R9 address after abort START", ack, 1);
    recv_byte(1'b0, d); chk(d == exp_mem[8'h30], "R9 no write on aborted byte", d, exp_mem[8'h30]);
    i2c_stop();
    chk(sda_oe == 1'b0, "R9 released after STOP", sda_oe, 0);
    chk(exp_q.size() == 0, "R9 no pending writes", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule